// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

A purely combinational adder for two N-bit unsigned operands and a carry-in. It produces an N-bit sum and a carry-out. All carries are computed at once. No carry ripples from bit to bit.

Each bit position first forms a generate/propagate pair. The carry-in is folded into the least significant pair, so it takes part in the prefix as the lowest element. A tree of identical combine cells then builds, for every bit, the group generate of all bits from zero up to that bit. Each combine cell merges a more significant pair with a less significant one, and the operand order is kept at every cell. Each group generate is the carry into the next bit. The sum is the per-bit propagate XORed with the incoming carry.

A parameter chooses the tree shape. The dense shape reaches every prefix in log2 N levels, with close to N cells per level. The sparse shape uses an upward reduction followed by a downward distribution. It needs 2·log2 N − 1 levels and far fewer cells. Both shapes give identical results.

Top module: `pfx_adder`

## Requirements
- R1: `sumOut` equals the low N bits of `opA + opB + carryIn` for every input combination.
- R2: `carryOut` equals bit N of `opA + opB + carryIn`, so the full (N+1)-bit result is exact.
- R3: `carryIn` acts as a weight-one addend below bit 0. With `opA` all ones, `opB` zero and `carryIn` = 1, the result is `sumOut` = 0 and `carryOut` = 1. With `carryIn` = 0, `sumOut` is all ones and `carryOut` = 0.
- R4: When every bit propagates (`opA ^ opB` all ones), `carryOut` equals `carryIn`.
- R5: When every bit kills (both operands zero), `carryOut` = 0 and `sumOut` equals `carryIn` in bit 0 and zero elsewhere.
- R6: When every bit generates (both operands all ones), `carryOut` = 1 and `sumOut` is all ones if `carryIn` = 1, or all ones except bit 0 if `carryIn` = 0.
- R7: The dense setting (`TOPO` = `TOPO_DENSE`, value 0) and the sparse setting (`TOPO` = `TOPO_SPARSE`, value 1) give bit-identical `sumOut` and `carryOut` for the same inputs.
- R8: A carry generated only in bit 0 reaches the top. For `opA` = 1, `opB` = 1 and an all-ones middle pattern, the carry crosses every level of the tree. For example, `opA` = all ones with `opB` = 1 gives `sumOut` = `carryIn` and `carryOut` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | N | First addend |
| opB | input | N | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | N | Sum bits |
| carryOut | output | 1 | Carry out of bit N−1 |

## Verification
The block has no registers, so every result is due in the same cycle as its operands. The bench changes the inputs just after a rising clock edge and compares the outputs at the following falling edge. By then the combinational paths of both tree shapes have settled. A behavioural model in the bench computes the (N+1)-bit sum with plain integer addition. The bench compares a dense and a sparse instance against that model and against each other on every cycle. The cycles cover directed carry-chain corners and pseudo-random operands.

// File: rtl/pfx_adder_pkg.sv
package pfx_adder_pkg;

  typedef enum logic {
    TOPO_DENSE  = 1'b0,
    TOPO_SPARSE = 1'b1
  } topoSel_e;

  // Merge a more significant (hi) pair with a less significant (lo) pair.
  // Result packed as {gen, prop}; order of arguments matters.
  function automatic logic [1:0] gpJoin(input logic hiGen, input logic hiProp,
                                        input logic loGen, input logic loProp);
    gpJoin = {hiGen | (hiProp & loGen), hiProp & loProp};
  endfunction

endpackage

// File: rtl/pfx_gp_stage.sv
module pfx_gp_stage #(
  parameter int N = 32
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         carryIn,
  output logic [N-1:0] bitProp,
  output logic [N-1:0] seedGen,
  output logic [N-1:0] seedProp
);
  logic [N-1:0] bitGen;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign bitGen[i]  = opA[i] & opB[i];
    assign bitProp[i] = opA[i] ^ opB[i];
    if (i == 0) begin : g_seed
      // carry-in enters as the least significant prefix element
      assign seedGen[i]  = bitGen[i] | (bitProp[i] & carryIn);
      assign seedProp[i] = 1'b0;
    end else begin : g_plain
      assign seedGen[i]  = bitGen[i];
      assign seedProp[i] = bitProp[i];
    end
  end
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree
  import pfx_adder_pkg::*;
#(
  parameter int       N    = 32,
  parameter topoSel_e TOPO = TOPO_DENSE
) (
  input  logic [N-1:0] seedGen,
  input  logic [N-1:0] seedProp,
  output logic [N-1:0] grpGen
);
  localparam int L = $clog2(N);

  if (TOPO == TOPO_DENSE) begin : g_dense
    logic [L:0][N-1:0] lvGen;
    logic [L:0][N-1:0] lvProp;
    logic unusedProp;
    assign lvGen[0]  = seedGen;
    assign lvProp[0] = seedProp;
    for (genvar s = 0; s < L; s++) begin : g_lvl
      localparam int DIST = 1 << s;
      for (genvar i = 0; i < N; i++) begin : g_node
        if (i >= DIST) begin : g_op
          assign {lvGen[s+1][i], lvProp[s+1][i]} =
            gpJoin(lvGen[s][i], lvProp[s][i], lvGen[s][i-DIST], lvProp[s][i-DIST]);
        end else begin : g_pass
          assign lvGen[s+1][i]  = lvGen[s][i];
          assign lvProp[s+1][i] = lvProp[s][i];
        end
      end
    end
    assign grpGen     = lvGen[L];
    assign unusedProp = ^lvProp[L];
  end else begin : g_sparse
    localparam int D = 2 * L - 1;
    logic [D:0][N-1:0] lvGen;
    logic [D:0][N-1:0] lvProp;
    logic unusedProp;
    assign lvGen[0]  = seedGen;
    assign lvProp[0] = seedProp;
    for (genvar s = 0; s < D; s++) begin : g_lvl
      localparam bit UP   = (s < L);
      localparam int DIST = UP ? (1 << s) : (1 << (2 * L - 2 - s));
      for (genvar i = 0; i < N; i++) begin : g_node
        localparam bit ACT = UP ? (((i + 1) % (2 * DIST)) == 0)
                                : ((((i + 1) % (2 * DIST)) == DIST) && ((i + 1) > DIST));
        if (ACT) begin : g_op
          assign {lvGen[s+1][i], lvProp[s+1][i]} =
            gpJoin(lvGen[s][i], lvProp[s][i], lvGen[s][i-DIST], lvProp[s][i-DIST]);
        end else begin : g_pass
          assign lvGen[s+1][i]  = lvGen[s][i];
          assign lvProp[s+1][i] = lvProp[s][i];
        end
      end
    end
    assign grpGen     = lvGen[D];
    assign unusedProp = ^lvProp[D];
  end
endmodule

// File: rtl/pfx_sum_stage.sv
module pfx_sum_stage #(
  parameter int N = 32
) (
  input  logic [N-1:0] bitProp,
  input  logic [N-1:0] grpGen,
  input  logic         carryIn,
  output logic [N-1:0] sumOut,
  output logic         carryOut
);
  logic [N-1:0] carryVec;
  assign carryVec = {grpGen[N-2:0], carryIn};
  assign sumOut   = bitProp ^ carryVec;
  assign carryOut = grpGen[N-1];
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder
  import pfx_adder_pkg::*;
#(
  parameter int       N    = 32,
  parameter topoSel_e TOPO = TOPO_DENSE
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         carryIn,
  output logic [N-1:0] sumOut,
  output logic         carryOut
);
  logic [N-1:0] bitProp, seedGen, seedProp, grpGen;

  pfx_gp_stage #(.N(N)) u_gp (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .bitProp(bitProp), .seedGen(seedGen), .seedProp(seedProp)
  );

  pfx_tree #(.N(N), .TOPO(TOPO)) u_tree (
    .seedGen(seedGen), .seedProp(seedProp), .grpGen(grpGen)
  );

  pfx_sum_stage #(.N(N)) u_sum (
    .bitProp(bitProp), .grpGen(grpGen), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );
endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
  parameter int N = 32
) (
  input logic [N-1:0] opA,
  input logic [N-1:0] opB,
  input logic         carryIn,
  input logic [N-1:0] sumOut,
  input logic         carryOut
);
  logic [N:0] fullRef;
  assign fullRef = {1'b0, opA} + {1'b0, opB} + {{N{1'b0}}, carryIn};

  always_comb begin
    // R1
    sum_match_chk: assert (sumOut == fullRef[N-1:0]) else $error("sum mismatch");
    // R2
    cout_match_chk: assert (carryOut == fullRef[N]) else $error("carry-out mismatch");
    // R4
    all_prop_chk: assert (!(&(opA ^ opB)) || (carryOut == carryIn))
      else $error("propagate chain broken");
    // R5
    all_kill_chk: assert (!((opA | opB) == '0) || (!carryOut && sumOut == {{(N-1){1'b0}}, carryIn}))
      else $error("kill case wrong");
    // R6
    all_gen_chk: assert (!(&(opA & opB)) || carryOut) else $error("generate case wrong");
    // R3
    cin_lsb_chk: assert (sumOut[0] == (opA[0] ^ opB[0] ^ carryIn)) else $error("lsb wrong");
  end
endmodule

bind pfx_adder pfx_adder_chk #(.N(N)) u_chk (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
);

// File: tb/test_pfx_adder.sv
`timescale 1ns/1ps
module test_pfx_adder;
  import pfx_adder_pkg::*;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opA, opB;
  logic carryIn;
  logic [W-1:0] sumD, sumS;
  logic coD, coS;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pfx_adder #(.N(W), .TOPO(TOPO_DENSE))  i_pfx_adder    (.opA(opA), .opB(opB), .carryIn(carryIn),
                                                          .sumOut(sumD), .carryOut(coD));
  pfx_adder #(.N(W), .TOPO(TOPO_SPARSE)) i_pfx_adder_sp (.opA(opA), .opB(opB), .carryIn(carryIn),
                                                          .sumOut(sumS), .carryOut(coS));

  task automatic checkOne(input string req);
    logic [W:0] expv;
    expv = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn};
    total++;
    if ({coD, sumD} !== expv) begin
      bad++;
      $display("FAIL %s dense: got %h expected %h", req, {coD, sumD}, expv);
    end
    total++;
    if ({coS, sumS} !== expv) begin
      bad++;
      $display("FAIL %s sparse: got %h expected %h", req, {coS, sumS}, expv);
    end
    total++;
    if ({coS, sumS} !== {coD, sumD}) begin
      bad++;
      $display("FAIL R7 shapes differ: got %h expected %h", {coS, sumS}, {coD, sumD});
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                       input string req);
    @(posedge clk); #1;
    opA = a; opB = b; carryIn = c;
    @(negedge clk);
    checkOne(req);
  endtask

  initial begin
    opA = '0; opB = '0; carryIn = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkOne("R5 reset zero");
    apply('1, '0, 1'b1, "R3 cin wraps");
    apply('1, '0, 1'b0, "R3 no cin");
    apply(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0, "R4 prop cin0");
    apply(32'h0F0F_F0F0, 32'hF0F0_0F0F, 1'b1, "R4 prop cin1");
    apply('0, '0, 1'b1, "R5 kill cin1");
    apply('1, '1, 1'b0, "R6 gen cin0");
    apply('1, '1, 1'b1, "R6 gen cin1");
    apply('1, 32'h1, 1'b0, "R8 long carry");
    apply(32'h7FFF_FFFF, 32'h1, 1'b0, "R8 carry to msb");
    apply(32'h8000_0000, 32'h8000_0000, 1'b1, "R2 msb gen");
    for (int k = 0; k < W; k++) begin
      apply(~(32'h1 << k), 32'h1 << k, 1'b1, "R8 walking");
    end
    for (int k = 0; k < 3000; k++) begin
      apply($urandom, $urandom, 1'($urandom), "R1 R2 random");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule